// File: doc/BRIEF.md
# Branch Trace Capture Filter

This block sits between the branch retirement path and a small branch trace buffer. Each cycle it may receive one retired branch together with its qualifiers. The qualifiers give the predictor source that supplied the prediction, the resolved direction, whether the target and the direction were predicted correctly, the privilege level, and the branch address. A configuration word selects which branches are worth keeping. It holds an enable bit per predictor source, three independent 2-bit outcome selectors and a 4-bit privilege mask. A qualifying branch raises a capture strobe and is written into an eight-slot circular record buffer.

The filter can be bypassed entirely, and then every retired branch is recorded. The buffer can run free, or a capture counter can tally the branches that were stored. Its contents can be inspected combinationally through a peek index.

Top module: `brtrace_filter`

## Requirements
- R1: Source code 0 is the target register predictor, 1 the target cache, 2 the address corrector. While filtering is on, a branch is kept only if the enable bit at index `br_src` of `cfg_src_en` is 1, and code 3 is never kept.
- R2: Direction selector `cfg_dir_mode`: 0 keeps nothing, 1 keeps not-taken branches, 2 keeps taken branches, 3 keeps both.
- R3: Target selector `cfg_tgt_mode`: 0 keeps nothing, 1 keeps branches with `br_tgt_ok`=0, 2 keeps those with `br_tgt_ok`=1, 3 keeps both.
- R4: Path selector `cfg_path_mode`: 0 keeps nothing, 1 keeps branches with `br_dir_ok`=0, 2 keeps those with `br_dir_ok`=1, 3 keeps both.
- R5: A branch at privilege level p (0..3) is kept only if bit p of the effective mask is 1. The effective mask is `cfg_priv_mask`, or `dflt_priv_mask` when `cfg_priv_mask` is zero.
- R6: A branch is kept only when `br_valid` is 1 and every enabled condition of R1 to R5 holds in the same cycle. Nothing is kept when `br_valid` is 0.
- R7: With `cfg_filter_on`=0, every valid branch is kept, whatever the other settings are.
- R8: One clock after a kept branch, `cap_strobe` is 1 for one cycle. `cap_record` then holds {priv[1:0], src[1:0], taken, tgt_ok, dir_ok, addr}, with the address in the low AW bits.
- R9: Kept records go into slot `wr_ptr`, and `wr_ptr` then advances by one and wraps from 7 to 0. `peek_data` shows the slot chosen by `peek_idx`.
- R10: `buf_full` becomes 1 once the write into slot 7 is made and stays 1 until reset.
- R11: `cap_count` rises by one for each kept branch while `cnt_en` is 1 and holds its value while `cnt_en` is 0.
- R12: After reset, `cap_strobe`, `wr_ptr`, `buf_full` and `cap_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_filter_on | input | 1 | 1 applies the filter, 0 records every branch |
| cfg_src_en | input | 3 | Per-source enables, bit index = source code |
| cfg_dir_mode | input | 2 | Taken/not-taken selector |
| cfg_tgt_mode | input | 2 | Target prediction selector |
| cfg_path_mode | input | 2 | Direction prediction selector |
| cfg_priv_mask | input | 4 | Privilege mask, zero selects default |
| dflt_priv_mask | input | 4 | Default privilege mask |
| cnt_en | input | 1 | Enables the capture counter |
| br_valid | input | 1 | A retired branch is present |
| br_src | input | 2 | Predictor source code |
| br_taken | input | 1 | Branch was taken |
| br_tgt_ok | input | 1 | Target predicted correctly |
| br_dir_ok | input | 1 | Direction predicted correctly |
| br_priv | input | 2 | Privilege level |
| br_addr | input | AW | Branch address |
| peek_idx | input | 3 | Buffer slot to inspect |
| cap_strobe | output | 1 | Record captured last cycle |
| cap_record | output | AW+7 | Captured record |
| wr_ptr | output | 3 | Next slot to be written |
| buf_full | output | 1 | Buffer has wrapped at least once |
| cap_count | output | CW | Captured-branch count |
| peek_data | output | AW+7 | Contents of slot `peek_idx` |

## Verification
On every cycle, the assertions check a set of structural rules. A strobe never appears without a valid branch one cycle earlier. The pointer steps by exactly one per capture and stays put otherwise. The full flag never drops. The counter only moves on a capture with counting enabled. While filtering is on, a zero selector or source code 3 never yields a capture. Only the bench sweeps can show that each selector encoding, each source enable and each privilege bit, with the default-mask fallback, keeps exactly the right branches. The same holds for the record layout and the contents of the wrapped buffer.

// File: rtl/brtrace_filter.sv
module brtrace_filter #(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  parameter int CW    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_filter_on,
  input  logic [2:0]            cfg_src_en,
  input  logic [1:0]            cfg_dir_mode,
  input  logic [1:0]            cfg_tgt_mode,
  input  logic [1:0]            cfg_path_mode,
  input  logic [3:0]            cfg_priv_mask,
  input  logic [3:0]            dflt_priv_mask,
  input  logic                  cnt_en,
  input  logic                  br_valid,
  input  logic [1:0]            br_src,
  input  logic                  br_taken,
  input  logic                  br_tgt_ok,
  input  logic                  br_dir_ok,
  input  logic [1:0]            br_priv,
  input  logic [AW-1:0]         br_addr,
  input  logic [$clog2(DEPTH)-1:0] peek_idx,
  output logic                  cap_strobe,
  output logic [AW+6:0]         cap_record,
  output logic [$clog2(DEPTH)-1:0] wr_ptr,
  output logic                  buf_full,
  output logic [CW-1:0]         cap_count,
  output logic [AW+6:0]         peek_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int RW = AW + 7;

  function automatic logic sel_ok(input logic [1:0] m, input logic c);
    return c ? m[1] : m[0];
  endfunction

  logic [3:0]    src_en4;
  logic [3:0]    eff_mask;
  logic          filt_pass;
  logic          hit;
  logic [RW-1:0] rec;
  logic [RW-1:0] mem [DEPTH];

  assign src_en4   = {1'b0, cfg_src_en};
  assign eff_mask  = (cfg_priv_mask != 4'd0) ? cfg_priv_mask : dflt_priv_mask;
  assign filt_pass = src_en4[br_src]
                   & sel_ok(cfg_dir_mode,  br_taken)
                   & sel_ok(cfg_tgt_mode,  br_tgt_ok)
                   & sel_ok(cfg_path_mode, br_dir_ok)
                   & eff_mask[br_priv];
  assign hit       = br_valid & (~cfg_filter_on | filt_pass);
  assign rec       = {br_priv, br_src, br_taken, br_tgt_ok, br_dir_ok, br_addr};
  assign peek_data = mem[peek_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_strobe <= 1'b0;
      cap_record <= '0;
      wr_ptr     <= '0;
      buf_full   <= 1'b0;
      cap_count  <= '0;
    end else begin
      cap_strobe <= hit;
      if (hit) begin
        cap_record <= rec;
        wr_ptr     <= wr_ptr + 1'b1;
        if (wr_ptr == PW'(DEPTH - 1)) buf_full <= 1'b1;
        if (cnt_en) cap_count <= cap_count + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (hit) mem[wr_ptr] <= rec;
  end

  AST_STROBE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |-> $past(br_valid)); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |-> wr_ptr == PW'($past(wr_ptr) + 1'b1)); // R9
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_strobe |-> $stable(wr_ptr)); // R9
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |=> buf_full); // R10
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_strobe && $past(cnt_en)) |-> cap_count == CW'($past(cap_count) + 1'b1)); // R11
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_strobe && $past(cnt_en)) |-> $stable(cap_count)); // R11
  AST_SRC3_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_strobe && $past(cfg_filter_on)) |-> cap_record[AW+4:AW+3] != 2'd3); // R1
  AST_DIR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_strobe && $past(cfg_filter_on)) |-> $past(cfg_dir_mode) != 2'd0); // R2
  AST_TGT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_strobe && $past(cfg_filter_on)) |-> $past(cfg_tgt_mode) != 2'd0); // R3
  AST_PATH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_strobe && $past(cfg_filter_on)) |-> $past(cfg_path_mode) != 2'd0); // R4
endmodule

// File: tb/brtrace_filter_test.sv
`timescale 1ns/1ps
module brtrace_filter_test;
  localparam int AW = 16;
  localparam int RW = AW + 7;

  logic clk = 0;
  logic rst_n = 0;
  logic filt_on = 1;
  logic [2:0] src_en = 3'd7;
  logic [1:0] dmode = 3, tmode = 3, pmode = 3;
  logic [3:0] pmask = 4'hF, dmask = 4'hF;
  logic cnt_en = 1;
  logic v = 0;
  logic [1:0] src = 0, priv = 0;
  logic tk = 0, tg = 0, dr = 0;
  logic [AW-1:0] addr = 0;
  logic [2:0] pidx = 0;
  logic cap_strobe, buf_full;
  logic [RW-1:0] cap_record, peek_data;
  logic [2:0] wr_ptr;
  logic [15:0] cap_count;

  int checks = 0, errors = 0;
  int e_ptr = 0, e_cnt = 0;
  bit e_full = 0;
  logic [RW-1:0] model [8];

  brtrace_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_filter_on(filt_on), .cfg_src_en(src_en),
    .cfg_dir_mode(dmode), .cfg_tgt_mode(tmode), .cfg_path_mode(pmode),
    .cfg_priv_mask(pmask), .dflt_priv_mask(dmask), .cnt_en(cnt_en),
    .br_valid(v), .br_src(src), .br_taken(tk), .br_tgt_ok(tg), .br_dir_ok(dr),
    .br_priv(priv), .br_addr(addr), .peek_idx(pidx),
    .cap_strobe(cap_strobe), .cap_record(cap_record), .wr_ptr(wr_ptr),
    .buf_full(buf_full), .cap_count(cap_count), .peek_data(peek_data));

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit keep_sel(input int m, input bit c);
    return (m == 3) || (m == 2 && c) || (m == 1 && !c);
  endfunction

  function automatic bit exp_keep();
    int mask;
    if (!v) return 0;
    if (!filt_on) return 1;
    mask = (pmask == 0) ? dmask : pmask;
    if (src == 3) return 0;
    if (((src_en >> src) & 1) == 0) return 0;
    if (!keep_sel(dmode, tk)) return 0;
    if (!keep_sel(tmode, tg)) return 0;
    if (!keep_sel(pmode, dr)) return 0;
    return ((mask >> priv) & 1) == 1;
  endfunction

  task automatic send(input bit vv, input int s, input bit t, input bit g, input bit d,
                      input int p, input string req);
    bit ek;
    logic [RW-1:0] er;
    v = vv; src = 2'(s); tk = t; tg = g; dr = d; priv = 2'(p); addr = addr + 1'b1;
    ek = exp_keep();
    er = {priv, src, tk, tg, dr, addr};
    @(negedge clk);
    if (ek) begin
      model[e_ptr] = er;
      if (e_ptr == 7) e_full = 1;
      e_ptr = (e_ptr + 1) % 8;
      if (cnt_en) e_cnt++;
    end
    check(cap_strobe == ek, req, cap_strobe, ek);
    if (ek) check(cap_record == er, "R8", cap_record, er);
    check(wr_ptr == 3'(e_ptr), "R9", wr_ptr, e_ptr);
    check(buf_full == e_full, "R10", buf_full, e_full);
    check(cap_count == 16'(e_cnt), "R11", cap_count, e_cnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(cap_strobe == 0, "R12", cap_strobe, 0);
    check(wr_ptr == 0, "R12", wr_ptr, 0);
    check(buf_full == 0, "R12", buf_full, 0);
    check(cap_count == 0, "R12", cap_count, 0);
    rst_n = 1;

    // R2 R3 R4: all selector encodings against all outcome patterns
    for (int m = 0; m < 64; m++) begin
      dmode = 2'(m); tmode = 2'(m >> 2); pmode = 2'(m >> 4);
      for (int a = 0; a < 32; a++)
        send(1, a & 3, a[2], a[3], a[4], (m + a) & 3, "R2_R3_R4");
    end
    dmode = 3; tmode = 3; pmode = 3;

    // R1 source enables, R6 invalid cycles
    for (int se = 0; se < 8; se++) begin
      src_en = 3'(se);
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 4; p++) begin
          send(1, s, p[0], p[1], 1, p, "R1");
          send(0, s, 1, 1, 1, p, "R6");
        end
    end
    src_en = 7;

    // R5 privilege mask with default fallback
    foreach (model[k]) begin end
    for (int dm = 0; dm < 3; dm++) begin
      dmask = (dm == 0) ? 4'h0 : (dm == 1) ? 4'h5 : 4'hA;
      for (int pm = 0; pm < 16; pm++) begin
        pmask = 4'(pm);
        for (int p = 0; p < 4; p++) send(1, p % 3, 1, 0, 1, p, "R5");
      end
    end
    pmask = 4'hF; dmask = 4'hF;

    // R7 bypass with blocking settings; R11 counter hold
    filt_on = 0; cnt_en = 0; src_en = 0; dmode = 0; tmode = 0; pmode = 0; pmask = 4'h0; dmask = 4'h0;
    for (int a = 0; a < 64; a++) send(a != 13, a & 3, a[2], a[3], a[4], a >> 4, "R7");
    filt_on = 1; cnt_en = 1;
    for (int a = 0; a < 8; a++) send(1, 0, 1, 1, 1, 0, "R6");
    src_en = 7; dmode = 3; tmode = 3; pmode = 3; pmask = 4'hF;
    for (int a = 0; a < 11; a++) send(1, a % 3, a[0], a[1], a[2], a & 3, "R11");

    // R9 buffer contents after wrapping
    v = 0;
    for (int i = 0; i < 8; i++) begin
      pidx = 3'(i);
      #1;
      check(peek_data == model[i], "R9", peek_data, model[i]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule